// File: doc/BRIEF.md
# Interleaved I/Q Parallel Output Sequencer

This block takes finished baseband results, one I/Q pair for a single channel or two pairs for a two-channel receiver, and serializes them onto one shared 16-bit two's complement bus. Each 23-bit internal result is cut down to a 16-bit slice whose weight is set by a 3-bit scale factor. If the cut would lose significant bits, the word saturates. Three status lines travel with the bus: a valid strobe, a marker that is high for in-phase words, and a marker that is high for channel A words.

A ready strobe starts one output burst. The burst is two words long (I then Q) in single-channel real and complex modes. It is four words long (A I, A Q, B I, B Q) in two-channel real mode. If a second result arrives while a burst is still running, a one-entry holding register keeps it, and its burst follows the current one with no gap. The choice between parallel and serial output is taken from a pin only while reset is asserted. When serial output is selected, this parallel sequencer stays silent.

Top module: `iq_par_out`

## Requirements
- R1: With scale factor s (0 to 7), each output word is bits [22-s : 7-s] of the 23-bit result. Arithmetically this is the result shifted right, with sign, by 7-s bits.
- R2: If the bits above the selected slice are not all equal to the slice's top bit, the word saturates: 16'h7FFF for a positive result and 16'h8000 for a negative one.
- R3: In mode 2'b00 (single-channel real), 2'b10 (complex) or 2'b11 (treated as single), a ready strobe produces exactly two valid words. The I word comes first and the Q word second, and both have the channel marker high.
- R4: In mode 2'b01 (two-channel real), a ready strobe produces four consecutive valid words in the order A I, A Q, B I, B Q.
- R5: The I/Q marker is high on I words and low on Q words, and it is low whenever valid is low.
- R6: The channel marker is high on channel A words and low on channel B words, and it is low whenever valid is low.
- R7: After valid falls, the bus keeps the last Q word until the next burst starts.
- R8: The parallel/serial pin is captured only while rst_n is low, and changing it after reset has no effect. When serial output is captured (pin low), ready strobes produce no valid words.
- R9: A ready strobe that arrives during a burst is held, and its burst begins on the clock right after the current burst's last word. Valid does not drop between the two bursts.
- R10: The first valid word appears in the clock after the ready strobe is sampled. During reset, and until the first burst, valid, both markers and the bus are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_sel_pin | input | 1 | Output type pin, 1 = parallel, captured during reset |
| in_mode | input | 2 | 00 single real, 01 two-channel real, 10 complex, 11 as single |
| scale | input | 3 | Output slice weight |
| res_valid | input | 1 | One-clock strobe: a new result set is ready |
| res_ai | input | 23 | Channel A in-phase result |
| res_aq | input | 23 | Channel A quadrature result |
| res_bi | input | 23 | Channel B in-phase result |
| res_bq | input | 23 | Channel B quadrature result |
| par_active | output | 1 | Captured output type, 1 = parallel |
| out_data | output | 16 | Output word |
| out_valid | output | 1 | Output word valid |
| out_iq | output | 1 | High on I words |
| out_ab | output | 1 | High on channel A words |

## Verification
The bench builds the block with its default widths: a 23-bit result, a 16-bit bus and a 3-bit scale. This keeps the full scale range, 0 to 7, small enough to sweep completely. Every scale value is combined with a spread of results that includes both extremes, values near the saturation limits and zero, so each slice position and both saturation directions are reached. Bursts are run in all four mode codes, back to back to exercise the holding register, and across a reset with the serial pin level to show that the output stays quiet.

// File: rtl/iq_par_out.sv
module iq_par_out #(
  parameter int RES_W = 23,
  parameter int OUT_W = 16,
  parameter int SCL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             par_sel_pin,
  input  logic [1:0]       in_mode,
  input  logic [SCL_W-1:0] scale,
  input  logic             res_valid,
  input  logic [RES_W-1:0] res_ai,
  input  logic [RES_W-1:0] res_aq,
  input  logic [RES_W-1:0] res_bi,
  input  logic [RES_W-1:0] res_bq,
  output logic             par_active,
  output logic [OUT_W-1:0] out_data,
  output logic             out_valid,
  output logic             out_iq,
  output logic             out_ab
);
  localparam int DROP = RES_W - OUT_W;
  localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_MAX = {1'b1, {(OUT_W-1){1'b0}}};

  function automatic logic [OUT_W-1:0] cut(input logic [RES_W-1:0] v, input logic [SCL_W-1:0] s);
    logic signed [RES_W-1:0] top;
    logic [RES_W-1:0] sh;
    int unsigned sa;
    sa  = (int'(s) > DROP) ? DROP : int'(s);
    sh  = v << sa;
    top = $signed(v) >>> (RES_W - 1 - sa);
    if (top == '0 || top == '1) cut = sh[RES_W-1 -: OUT_W];
    else cut = v[RES_W-1] ? NEG_MAX : POS_MAX;
  endfunction

  logic [OUT_W-1:0] sw   [4];
  logic [OUT_W-1:0] cur  [4];
  logic [OUT_W-1:0] hold [4];
  logic cur_four, hold_four, hold_full, busy, par_q;
  logic [1:0] idx;

  wire four_in = (in_mode == 2'b01);
  wire accept  = res_valid && par_q;
  wire last    = busy && (idx == (cur_four ? 2'd3 : 2'd1));

  assign sw[0] = cut(res_ai, scale);
  assign sw[1] = cut(res_aq, scale);
  assign sw[2] = cut(res_bi, scale);
  assign sw[3] = cut(res_bq, scale);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_q     <= par_sel_pin;
      busy      <= 1'b0;
      idx       <= 2'd0;
      cur_four  <= 1'b0;
      hold_four <= 1'b0;
      hold_full <= 1'b0;
      for (int i = 0; i < 4; i++) begin
        cur[i]  <= '0;
        hold[i] <= '0;
      end
    end else if (busy && !last) begin
      idx <= idx + 2'd1;
      if (accept) begin
        hold_full <= 1'b1;
        hold_four <= four_in;
        for (int i = 0; i < 4; i++) hold[i] <= sw[i];
      end
    end else if (hold_full) begin
      busy      <= 1'b1;
      idx       <= 2'd0;
      cur_four  <= hold_four;
      for (int i = 0; i < 4; i++) cur[i] <= hold[i];
      hold_full <= accept;
      if (accept) begin
        hold_four <= four_in;
        for (int i = 0; i < 4; i++) hold[i] <= sw[i];
      end
    end else if (accept) begin
      busy     <= 1'b1;
      idx      <= 2'd0;
      cur_four <= four_in;
      for (int i = 0; i < 4; i++) cur[i] <= sw[i];
    end else begin
      busy <= 1'b0;
    end
  end

  assign par_active = par_q;
  assign out_valid  = busy;
  assign out_data   = cur[idx];
  assign out_iq     = busy & ~idx[0];
  assign out_ab     = busy & ~idx[1];

  // R3
  i_then_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_iq) |=> (out_valid && !out_iq));

  // R5
  markers_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_iq && !out_ab));

  // R7
  q_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && $past(!out_valid)) |-> $stable(out_data));

  // R8
  serial_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !par_active |-> !out_valid);

  // R8
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(par_active));

  // R4
  b_follows_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ab) |-> !($past(out_valid) && $past(!out_ab) && $past(!out_iq)) || !out_iq);
endmodule

// File: tb/tb_iq_par_out.sv
module tb_iq_par_out;
  logic clk = 0, rst_n = 0, pin = 1, res_valid = 0;
  logic [1:0] in_mode = 0;
  logic [2:0] scale = 0;
  logic [22:0] ai = 0, aq = 0, bi = 0, bq = 0;
  logic par_active, out_valid, out_iq, out_ab;
  logic [15:0] out_data;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  iq_par_out dut (.clk(clk), .rst_n(rst_n), .par_sel_pin(pin), .in_mode(in_mode),
    .scale(scale), .res_valid(res_valid), .res_ai(ai), .res_aq(aq), .res_bi(bi),
    .res_bq(bq), .par_active(par_active), .out_data(out_data), .out_valid(out_valid),
    .out_iq(out_iq), .out_ab(out_ab));

  function automatic logic [15:0] expw(input logic [22:0] v, input int s);
    longint x;
    x = longint'($signed(v)) >>> (7 - s);
    if (x > 32767) x = 32767;
    if (x < -32768) x = -32768;
    return x[15:0];
  endfunction

  task automatic chk(input string tag, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expect_word(input string tag, input logic [15:0] d, input logic iq, input logic ab);
    @(negedge clk);
    chk(tag, {out_valid, out_iq, out_ab, out_data}, {1'b1, iq, ab, d});
  endtask

  task automatic run_burst(input logic [1:0] m, input int s, input logic [22:0] v0,
                           input logic [22:0] v1, input logic [22:0] v2, input logic [22:0] v3);
    logic [15:0] lastq;
    @(negedge clk);
    in_mode = m; scale = 3'(s); ai = v0; aq = v1; bi = v2; bq = v3; res_valid = 1;
    @(negedge clk);
    res_valid = 0;
    chk("R10 first word", {out_valid, out_iq, out_ab, out_data}, {3'b111, expw(v0, s)});
    expect_word("R1 R2 R5 A Q", expw(v1, s), 1'b0, 1'b1);
    lastq = expw(v1, s);
    if (m == 2'b01) begin
      expect_word("R4 R6 B I", expw(v2, s), 1'b1, 1'b0);
      expect_word("R4 R6 B Q", expw(v3, s), 1'b0, 1'b0);
      lastq = expw(v3, s);
    end
    @(negedge clk);
    chk(m == 2'b01 ? "R4 R7 end" : "R3 R7 end", {out_valid, out_iq, out_ab, out_data}, {3'b000, lastq});
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [22:0] v;
    pin = 1;
    repeat (3) @(negedge clk);
    chk("R10 reset", {par_active, out_valid, out_iq, out_ab, out_data}, {4'b1000, 16'h0});
    rst_n = 1;
    @(negedge clk);
    chk("R10 idle", {par_active, out_valid, out_iq, out_ab, out_data}, {4'b1000, 16'h0});

    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 24; k++) begin
        case (k)
          0: v = 23'h3FFFFF;
          1: v = 23'h400000;
          2: v = 23'h0;
          3: v = 23'h7FFFFF;
          default: v = 23'((k * k * 48611 + k * 9173) * (s + 1));
        endcase
        run_burst(2'b01, s, v, ~v, 23'($signed(v) >>> 4), v ^ 23'h155555);
      end
      run_burst(2'b00, s, 23'((s + 1) << (14 + s)), 23'(-((s + 1) << (14 + s))), 0, 0);
    end

    // R1 exact boundary for scale 7: largest non-saturating values
    run_burst(2'b10, 7, 23'h007FFF, 23'h7F8000, 0, 0);
    // R2 just beyond the boundary
    run_burst(2'b11, 7, 23'h008000, 23'h7F7FFF, 0, 0);
    run_burst(2'b00, 0, 23'h3FFF80, 23'h400000, 0, 0);

    // R9 back-to-back bursts through the holding register
    @(negedge clk);
    in_mode = 2'b01; scale = 3'd7; ai = 23'd1; aq = 23'd2; bi = 23'd3; bq = 23'd4; res_valid = 1;
    @(negedge clk);
    in_mode = 2'b00; ai = 23'd5; aq = 23'd6; res_valid = 1;
    chk("R9 first A I", {out_valid, out_iq, out_ab, out_data}, {3'b111, 16'd1});
    @(negedge clk);
    res_valid = 0;
    chk("R9 A Q", {out_valid, out_iq, out_ab, out_data}, {3'b101, 16'd2});
    expect_word("R9 B I", 16'd3, 1'b1, 1'b0);
    expect_word("R9 B Q", 16'd4, 1'b0, 1'b0);
    expect_word("R9 held I", 16'd5, 1'b1, 1'b1);
    expect_word("R9 held Q", 16'd6, 1'b0, 1'b1);
    @(negedge clk);
    chk("R9 R7 end", {out_valid, out_iq, out_ab, out_data}, {3'b000, 16'd6});
    repeat (3) @(negedge clk);
    chk("R7 still held", {out_valid, out_data}, {1'b0, 16'd6});

    // R8 serial selection captured in reset, later pin change ignored
    rst_n = 0; pin = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    pin = 1;
    @(negedge clk);
    in_mode = 2'b01; ai = 23'd9; res_valid = 1;
    @(negedge clk);
    res_valid = 0;
    for (int c = 0; c < 6; c++) begin
      chk("R8 serial quiet", {par_active, out_valid, out_iq, out_ab, out_data}, {4'b0000, 16'h0});
      @(negedge clk);
    end

    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 parallel again", {15'h0, par_active}, {15'h0, 1'b1});
    run_burst(2'b00, 3, 23'h012345, 23'h7EDCBA, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule